// File: doc/BRIEF.md
# Vector Coprocessor Enable and Issue Gate

This block decides whether a scalar core may hand work to an attached vector coprocessor. It keeps a small status word made of an enable bit and one sticky flag per hardware error source. Each issue request carries one of four kinds. Two kinds are work for the coprocessor: a vector operation, or a move to or from a vector register. The other two reach the status word directly: a control write and a control read. Work that the gate accepts enters a pending queue, and the coprocessor side pops the queue in order. Work that the gate refuses raises a disabled fault toward the scalar side. The fault carries exception vector offset 0x68.

The scalar side does not see the enable bit at once. It sees a copy that lags the enable bit by 0 to 3 cycles, selected at run time. This makes the race window testable: while the copy still reads enabled, work is still queued, and that work drains normally after a software disable. A hardware error acts differently. It clears the enable bit, sets its flag, and flushes the queue immediately. Anything that slips into the queue during the lag window is flushed when software re-enables the coprocessor. A control read stalls until the lagging copy matches the real enable bit, so the status it returns matches what the scalar side will act on.

Top module: `vcop_issue_gate`

## Requirements
- R1: After reset the enable bit is 0, all error flags are 0, the queue is empty, `busy` is 0 and no fault or read response is pending.
- R2: A control write (`req_kind`=2) sets the enable bit to `req_wdata[0]`. Each 1 in `req_wdata[i+1]` clears error flag i. The status word has the enable bit in bit 0 and error flag i in bit i+1.
- R3: A 1 on `err_in[i]` clears the enable bit and sets error flag i on the next edge. This takes priority over a control write in the same cycle. The flag stays set until a control write clears it.
- R4: A vector operation (`req_kind`=0) or transfer (`req_kind`=1) made while the scalar-side view is enabled is queued in arrival order with its payload. When the queue holds `QDEPTH` entries, `req_ready` is 0 for these kinds.
- R5: A vector operation or transfer made while the scalar-side view is disabled is accepted but not queued. The cycle after it is accepted, `fault_valid` pulses with `fault_vec` = 0x68.
- R6: The scalar-side view equals the enable bit delayed by `dly_sel` cycles (0 to 3). Work issued inside that lag window is queued.
- R7: After a software disable, entries already in the queue (including ones from the lag window) still pop in order through `q_pop`.
- R8: A hardware error empties the queue on the next edge, so `busy` and `q_valid` are 0 the cycle after the error, even if a push happened in the same cycle.
- R9: A control write of enable=1 made after a hardware error empties the queue. The clearing is in force again only after a new error.
- R10: A control read (`req_kind`=3) has `req_ready` 0 while the scalar-side view differs from the enable bit. Once accepted, `rd_valid` pulses on the next cycle with `rd_data` holding the status word.
- R11: Control writes always have `req_ready` 1, whether the coprocessor is enabled or disabled.
- R12: `busy` is 1 exactly while the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dly_sel | input | 2 | Lag in cycles of the scalar-side enable view |
| req_valid | input | 1 | Issue request present |
| req_kind | input | 2 | 0 vector op, 1 transfer, 2 control write, 3 control read |
| req_wdata | input | 4 | Control write data (status word format) |
| req_payload | input | 8 | Instruction payload for queued kinds |
| req_ready | output | 1 | Request is taken this cycle when valid |
| fault_valid | output | 1 | Disabled fault pulse |
| fault_vec | output | 8 | Fault exception vector offset (0x68) |
| rd_valid | output | 1 | Control read response pulse |
| rd_data | output | 4 | Status word returned by a control read |
| err_in | input | 3 | Hardware error sources, one per flag |
| q_valid | output | 1 | Queue head present |
| q_payload | output | 8 | Queue head payload |
| q_pop | input | 1 | Coprocessor consumes the queue head |
| busy | output | 1 | Queue is non-empty |

## Verification
A wrong enable bit or a wrong lag position shows at `req_ready` and `fault_valid` on the first vector request after the faulty edge. A control read held back or released at the wrong cycle shows that the lag count is off. A missed or stray flush shows on `busy` and `q_valid` one cycle after the error or re-enable write, and a reordered or lost entry shows at `q_payload` on the next pop. The bench's reference model follows the status word, the lag history and the queue contents, and compares every output on every cycle. A stale status word therefore surfaces at the next `rd_data` response.

// File: rtl/vcop_pkg.sv
package vcop_pkg;
   typedef enum logic [1:0] {
      K_VOP   = 2'd0,
      K_XFER  = 2'd1,
      K_CWR   = 2'd2,
      K_CRD   = 2'd3
   } req_kind_e;

   localparam logic [7:0] DISABLED_FAULT_VEC = 8'h68;
endpackage

// File: rtl/vcop_view_delay.sv
module vcop_view_delay #(
   parameter int MAXDLY = 3,
   localparam int SELW  = $clog2(MAXDLY + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SELW-1:0] sel,
   input  logic            en,
   output logic            view
);
   generate
      if (MAXDLY < 1) begin : g_bad
         $error("MAXDLY must be at least 1");
      end
   endgenerate

   logic [MAXDLY-1:0] hist;

   always_ff @(posedge clk) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[MAXDLY-2:0], en};
   end

   always_comb begin
      if (sel == '0)                      view = en;
      else if (int'(sel) > MAXDLY)        view = hist[MAXDLY-1];
      else                                view = hist[int'(sel) - 1];
   end
endmodule

// File: rtl/vcop_status_reg.sv
module vcop_status_reg #(
   parameter int NERR = 3,
   localparam int SW  = NERR + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [SW-1:0]   wdata,
   input  logic [NERR-1:0] err,
   output logic            en,
   output logic [NERR-1:0] flags,
   output logic            flush
);
   logic hw_dis;
   logic err_any;

   assign err_any = |err;
   assign flush   = err_any | (wr & wdata[0] & hw_dis);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         hw_dis <= 1'b0;
         flags  <= '0;
      end else begin
         flags <= (flags & ~(wr ? wdata[SW-1:1] : '0)) | err;
         if (err_any) begin
            en     <= 1'b0;
            hw_dis <= 1'b1;
         end else if (wr) begin
            en <= wdata[0];
            if (wdata[0]) hw_dis <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vcop_pending_fifo.sv
module vcop_pending_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   input  logic         flush,
   output logic         full,
   output logic         valid,
   output logic [W-1:0] dout
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad
         $error("DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] rp, wp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign valid   = (cnt != '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign dout    = mem[rp];
   assign do_push = push & ~full;
   assign do_pop  = pop & valid;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/vcop_issue_gate.sv
module vcop_issue_gate
   import vcop_pkg::*;
#(
   parameter int NERR   = 3,
   parameter int PW     = 8,
   parameter int QDEPTH = 4,
   parameter int MAXDLY = 3,
   localparam int SW    = NERR + 1,
   localparam int DW    = $clog2(MAXDLY + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   dly_sel,
   input  logic            req_valid,
   input  logic [1:0]      req_kind,
   input  logic [SW-1:0]   req_wdata,
   input  logic [PW-1:0]   req_payload,
   output logic            req_ready,
   output logic            fault_valid,
   output logic [7:0]      fault_vec,
   output logic            rd_valid,
   output logic [SW-1:0]   rd_data,
   input  logic [NERR-1:0] err_in,
   output logic            q_valid,
   output logic [PW-1:0]   q_payload,
   input  logic            q_pop,
   output logic            busy
);
   logic            st_en;
   logic [NERR-1:0] st_flags;
   logic            flush;
   logic            view_en;
   logic            q_full;
   logic            is_work, fire, push, wr_fire, rd_fire;
   req_kind_e       kind;

   assign kind    = req_kind_e'(req_kind);
   assign is_work = (kind == K_VOP) || (kind == K_XFER);

   always_comb begin
      unique case (kind)
         K_VOP, K_XFER: req_ready = ~view_en | ~q_full;
         K_CWR:         req_ready = 1'b1;
         K_CRD:         req_ready = (view_en == st_en);
         default:       req_ready = 1'b0;
      endcase
   end

   assign fire    = req_valid & req_ready;
   assign push    = fire & is_work & view_en;
   assign wr_fire = fire & (kind == K_CWR);
   assign rd_fire = fire & (kind == K_CRD);

   vcop_status_reg #(.NERR(NERR)) i_status (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_fire),
      .wdata (req_wdata),
      .err   (err_in),
      .en    (st_en),
      .flags (st_flags),
      .flush (flush)
   );

   vcop_view_delay #(.MAXDLY(MAXDLY)) i_view (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (dly_sel),
      .en    (st_en),
      .view  (view_en)
   );

   vcop_pending_fifo #(.DEPTH(QDEPTH), .W(PW)) i_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (req_payload),
      .pop   (q_pop),
      .flush (flush),
      .full  (q_full),
      .valid (q_valid),
      .dout  (q_payload)
   );

   assign busy      = q_valid;
   assign fault_vec = DISABLED_FAULT_VEC;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_valid <= 1'b0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
      end else begin
         fault_valid <= fire & is_work & ~view_en;
         rd_valid    <= rd_fire;
         if (rd_fire) rd_data <= {st_flags, st_en};
      end
   end
endmodule

// File: rtl/vcop_issue_gate_chk.sv
module vcop_issue_gate_chk #(
   parameter int NERR = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [1:0]      req_kind,
   input logic [NERR:0]   req_wdata,
   input logic            req_ready,
   input logic            fault_valid,
   input logic [NERR-1:0] err_in,
   input logic            busy,
   input logic            q_valid,
   input logic            st_en,
   input logic            view_en,
   input logic            q_full
);
   assert_err_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_in) |=> !st_en);

   assert_err_flushes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_in) |=> (!busy && !q_valid));

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_kind[1] && view_en && q_full) |-> !req_ready);

   assert_fault_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> $past(req_valid && req_ready && !req_kind[1] && !view_en));

   assert_read_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 2'd3 && view_en != st_en) |-> !req_ready);

   assert_write_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 2'd2 && req_wdata[0] && err_in == '0) |=> st_en);

   assert_write_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 2'd2) |-> req_ready);
endmodule

bind vcop_issue_gate vcop_issue_gate_chk #(.NERR(NERR)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_kind    (req_kind),
   .req_wdata   (req_wdata),
   .req_ready   (req_ready),
   .fault_valid (fault_valid),
   .err_in      (err_in),
   .busy        (busy),
   .q_valid     (q_valid),
   .st_en       (st_en),
   .view_en     (view_en),
   .q_full      (q_full)
);

// File: tb/test_vcop_issue_gate.sv
`timescale 1ns/1ps
module test_vcop_issue_gate;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] dly_sel = '0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [3:0] req_wdata = '0;
   logic [7:0] req_payload = '0;
   logic       req_ready, fault_valid, rd_valid, q_valid, busy;
   logic [7:0] fault_vec, q_payload;
   logic [3:0] rd_data;
   logic [2:0] err_in = '0;
   logic       q_pop = 1'b0;

   always #2 clk = ~clk;

   vcop_issue_gate i_vcop_issue_gate (.*);

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   int m_en = 0, m_flags = 0, m_hw = 0;
   int m_hist[3] = '{0, 0, 0};
   int m_q[$];
   int m_fault = 0, m_rdv = 0, m_rdd = 0;
   int pay = 1;

   task automatic cmp(input int act, input int exp, input string tag);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_view();
      return (dly_sel == 0) ? m_en : m_hist[dly_sel - 1];
   endfunction

   function automatic int m_ready();
      if (req_kind <= 1) return (m_view() == 0 || m_q.size() < 4) ? 1 : 0;
      if (req_kind == 2) return 1;
      return (m_view() == m_en) ? 1 : 0;
   endfunction

   // one clock: inputs already set after negedge; compare, then advance model
   task automatic cyc();
      int rdy, fire, work, wr, rd, errany;
      #1;
      rdy = m_ready();
      cmp(int'(req_ready), rdy, req_kind <= 1 ? "R4" : (req_kind == 2 ? "R11" : "R10"));
      cmp(int'(q_valid), m_q.size() > 0, "R4");
      if (m_q.size() > 0) cmp(int'(q_payload), m_q[0], "R4");
      cmp(int'(busy), m_q.size() > 0, "R12");
      cmp(int'(fault_valid), m_fault, "R5");
      if (m_fault) cmp(int'(fault_vec), 'h68, "R5");
      cmp(int'(rd_valid), m_rdv, "R10");
      if (m_rdv) cmp(int'(rd_data), m_rdd, "R2");
      fire   = req_valid && rdy;
      work   = req_kind <= 1;
      wr     = fire && req_kind == 2;
      rd     = fire && req_kind == 3;
      errany = err_in != 0;
      m_fault = fire && work && m_view() == 0;
      m_rdv   = rd;
      if (rd) m_rdd = (m_flags << 1) | m_en;
      if (errany || (wr && req_wdata[0] && m_hw)) m_q.delete();
      else begin
         if (q_pop && m_q.size() > 0) void'(m_q.pop_front());
         if (fire && work && m_view() == 1) m_q.push_back(int'(req_payload));
      end
      m_hist[2] = m_hist[1];
      m_hist[1] = m_hist[0];
      m_hist[0] = m_en;
      m_flags = (m_flags & ~(wr ? int'(req_wdata[3:1]) : 0)) | int'(err_in);
      if (errany) begin m_en = 0; m_hw = 1; end
      else if (wr) begin
         m_en = req_wdata[0];
         if (req_wdata[0]) m_hw = 0;
      end
      @(negedge clk);
      req_valid = 0; err_in = '0; q_pop = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask
   task automatic op(input int kind);
      req_valid = 1; req_kind = kind[1:0]; req_payload = pay[7:0]; pay++;
      cyc();
   endtask
   task automatic wr(input int d);
      req_valid = 1; req_kind = 2; req_wdata = d[3:0];
      cyc();
   endtask
   task automatic rd_hold(input int n);
      for (int i = 0; i < n; i++) begin
         req_valid = 1; req_kind = 3; cyc();
      end
   endtask
   task automatic pop(input int n);
      for (int i = 0; i < n; i++) begin q_pop = 1; cyc(); end
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state seen at the ports
      cmp(int'(busy), 0, "R1"); cmp(int'(q_valid), 0, "R1");
      cmp(int'(fault_valid), 0, "R1"); cmp(int'(rd_valid), 0, "R1");
      idle(1);
      rd_hold(1); idle(1);
      // R5 with dly 0: disabled, op faults
      op(0); op(1); idle(1);
      // R2 enable, R4 fill to full and stall
      wr(1); idle(1);
      op(0); op(1); op(0); op(0);
      req_valid = 1; req_kind = 0; req_payload = 8'hEE; cyc();   // R4 full stall
      cmp(int'(busy), 1, "R12");
      pop(2); op(0); pop(3);
      rd_hold(1); idle(1);
      // R6/R7: dly 2, software disable, ops in window queued then drained
      dly_sel = 2; idle(3);
      op(0); wr(0); op(0); op(1); rd_hold(1); op(0); op(1);
      rd_hold(2); idle(1);
      pop(4); cmp(int'(busy), 0, "R7");
      // R3/R8: error flush while queued, window ops, then R9 re-enable flush
      dly_sel = 3; wr(1); idle(4);
      op(0); op(0);
      req_valid = 1; req_kind = 0; req_payload = pay[7:0]; pay++; err_in = 3'b010; cyc();
      cmp(int'(busy), 0, "R8");
      op(0); op(0); op(0); idle(1);
      cmp(int'(busy), 1, "R6");
      rd_hold(1); idle(1);
      cmp(int'(rd_data), 4'b0100, "R3");
      wr(1);
      cmp(int'(busy), 0, "R9");
      idle(4); rd_hold(1); idle(1);
      // R2: W1C flag, R3 priority over write
      wr(4'b0101); rd_hold(3); idle(1);
      cmp(int'(rd_data), 4'b0001, "R2");
      req_valid = 1; req_kind = 2; req_wdata = 4'b0001; err_in = 3'b101; cyc();
      rd_hold(5); idle(1);
      cmp(int'(rd_data), 4'b1010, "R3");
      // dly 1: enable again, ops, R11 writes while disabled
      dly_sel = 1; wr(4'b1111); idle(2); op(0); op(1);
      wr(0); op(0); op(0); wr(0); rd_hold(2); pop(4);
      idle(2);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule